// File: doc/BRIEF.md
# Double-Buffered DAC Register Interface

This block is a byte-wide register slave on a simple synchronous host bus. It sits between the host and a 12-bit digital-to-analog converter and a 16-bit digital-input port. The host writes a converter code in two byte writes. The low byte goes into a hidden staging register. The converter code changes only when the high nibble is written, and all twelve bits change in the same clock edge.

The block also returns the 16-bit digital-input word as two byte reads. Software must write the low byte first and the high nibble second. Each high-nibble write commits a new code and raises a one-cycle update pulse. That pulse is the only flow signal on the converter side. It has no back-pressure, so the converter must accept every pulse.

The bus has no handshake. A write takes effect at the clock edge where the write strobe is sampled. Read data appears in the cycle after the read strobe and is zero in every other cycle.

Top module: `dacbuf_regs`

## Requirements
- R1: After reset, `dac_code` is 0, `dac_load` is 0 and `bus_rdata` is 0. The staging byte is also 0, so a first write of 0x0A to offset 5 yields code 0xA00.
- R2: A write to offset 4 (binary 100) stores `bus_wdata` in the staging byte. It changes neither `dac_code` nor `dac_load`.
- R3: A write to offset 5 (binary 101) sets `dac_code` to {`bus_wdata[3:0]`, staging byte} at that clock edge. Bits 7:4 of that write data are ignored.
- R4: `dac_load` is high for exactly the one cycle that follows each offset-5 write, which is the cycle in which the new code first appears. It is low otherwise.
- R5: Consecutive offset-5 writes each commit again, reusing the staging byte. Each one raises `dac_load`.
- R6: A read of offset 6 returns digital-input bits 7:0 on `bus_rdata` in the cycle after the read strobe.
- R7: A read of offset 7 returns digital-input bits 15:8 on `bus_rdata` in the cycle after the read strobe.
- R8: A read of any offset from 0 to 5 returns 0. In a cycle that follows no read strobe, `bus_rdata` is 0.
- R9: `din` passes through two register stages before the read path. A change of `din` is missed by reads sampled at the next two edges and is seen by a read sampled at the third edge.
- R10: `dac_code` holds its value in every cycle that does not follow an offset-5 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| dac_code | output | 12 | Code presented to the converter |
| dac_load | output | 1 | One-cycle pulse on each commit |
| din | input | 16 | Asynchronous digital inputs |

## Verification
The bench writes a low byte alone and checks that the converter code and the pulse stay put. A design that passes the low byte straight through would show a half-updated code. It commits with junk in the upper data nibble to catch a design that lets bits 7:4 leak into the code. It issues back-to-back high-nibble writes to catch a pulse that does not repeat or a staging byte that is cleared after a commit. It steps `din` and reads it on three consecutive edges, which exposes a synchroniser with the wrong number of stages, and it reads unmapped offsets to catch stale data on the read bus.

// File: rtl/dacbuf_pkg.sv
package dacbuf_pkg;
  localparam int ADDR_W  = 3;
  localparam int BYTE_W  = 8;
  localparam int CODE_W  = 12;
  localparam int DIN_W   = 16;
  localparam logic [ADDR_W-1:0] OFS_CODE_LO = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_CODE_HI = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_DIN_LO  = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_DIN_HI  = 3'd7;
endpackage

// File: rtl/dacbuf_decode.sv
module dacbuf_decode
  import dacbuf_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              we_lo,
  output logic              we_hi
);
  always_comb begin
    we_lo = wr && (addr == OFS_CODE_LO);
    we_hi = wr && (addr == OFS_CODE_HI);
  end
endmodule

// File: rtl/dacbuf_stage.sv
module dacbuf_stage
  import dacbuf_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_lo,
  input  logic          we_hi,
  input  logic [BW-1:0] wdata,
  output logic [CW-1:0] code,
  output logic          load
);
  localparam int HI_W = CW - BW;
  logic [BW-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      code    <= '0;
      load    <= 1'b0;
    end else begin
      if (we_lo) stage_q <= wdata;
      load <= we_hi;
      if (we_hi) code <= {wdata[HI_W-1:0], stage_q};
    end
  end
endmodule

// File: rtl/dacbuf_sync.sv
module dacbuf_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[s] <= '0;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dacbuf_rdmux.sv
module dacbuf_rdmux
  import dacbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DIN_W-1:0]  din_s,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] sel;

  always_comb begin
    unique case (addr)
      OFS_DIN_LO: sel = din_s[BYTE_W-1:0];
      OFS_DIN_HI: sel = din_s[DIN_W-1:BYTE_W];
      default:    sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else rdata <= rd ? sel : '0;
  end
endmodule

// File: rtl/dacbuf_regs.sv
module dacbuf_regs
  import dacbuf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_load,
  input  logic [DIN_W-1:0]  din
);
  logic we_lo, we_hi;
  logic [DIN_W-1:0] din_s;

  dacbuf_decode u_dec (
    .addr(bus_addr), .wr(bus_wr), .we_lo(we_lo), .we_hi(we_hi)
  );

  dacbuf_stage #(.CW(CODE_W), .BW(BYTE_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .we_lo(we_lo), .we_hi(we_hi),
    .wdata(bus_wdata), .code(dac_code), .load(dac_load)
  );

  dacbuf_sync #(.W(DIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(din), .q(din_s)
  );

  dacbuf_rdmux u_rd (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .addr(bus_addr),
    .din_s(din_s), .rdata(bus_rdata)
  );
endmodule

// File: rtl/dacbuf_regs_chk.sv
module dacbuf_regs_chk
  import dacbuf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic [CODE_W-1:0] dac_code,
  input logic              dac_load
);
  logic hi_wr;
  assign hi_wr = bus_wr && (bus_addr == OFS_CODE_HI);

  // R4
  load_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> dac_load);
  // R4
  load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_wr |=> !dac_load);
  // R3
  commit_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> dac_code[CODE_W-1:BYTE_W] == $past(bus_wdata[CODE_W-BYTE_W-1:0]));
  // R10
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_wr |=> $stable(dac_code));
  // R8
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0);
  // R8
  unmapped_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr < OFS_DIN_LO) |=> bus_rdata == '0);
endmodule

bind dacbuf_regs dacbuf_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .dac_code(dac_code), .dac_load(dac_load)
);

// File: tb/sim_dacbuf_regs.sv
module sim_dacbuf_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [11:0] dac_code;
  logic        dac_load;
  logic [15:0] din = '0;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dacbuf_regs u0 (.*);

  // {low byte, high-write data, expected code}
  localparam logic [27:0] VEC [6] = '{
    {8'h34, 8'h02, 12'h234}, {8'hFF, 8'h0F, 12'hFFF},
    {8'h00, 8'h00, 12'h000}, {8'hA5, 8'hF3, 12'h3A5},
    {8'h01, 8'h80, 12'h001}, {8'h7E, 8'h5C, 12'hC7E}};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    logic [7:0] r;
    logic [11:0] held;
    repeat (3) @(negedge clk);
    chk("R1 code", {4'h0, dac_code}, 16'h0);
    chk("R1 load", {15'h0, dac_load}, 16'h0);
    chk("R1 rdata", {8'h0, bus_rdata}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    wr(3'd5, 8'h0A);
    chk("R1 staging zero", {4'h0, dac_code}, 16'h0A00);
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      held = dac_code;
      wr(3'd4, VEC[i][27:20]);
      chk("R2 code unchanged", {4'h0, dac_code}, {4'h0, held});
      chk("R2 no load", {15'h0, dac_load}, 16'h0);
      wr(3'd5, VEC[i][19:12]);
      chk("R3 code", {4'h0, dac_code}, {4'h0, VEC[i][11:0]});
      chk("R4 load", {15'h0, dac_load}, 16'h1);
      @(negedge clk);
      chk("R4 single pulse", {15'h0, dac_load}, 16'h0);
      chk("R10 hold", {4'h0, dac_code}, {4'h0, VEC[i][11:0]});
    end

    // R5 back-to-back commits reuse staging byte 0x7E
    bus_addr = 3'd5; bus_wdata = 8'h01; bus_wr = 1'b1;
    @(negedge clk);
    chk("R5 first", {3'h0, dac_load, dac_code}, 16'h117E);
    bus_wdata = 8'h09;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R5 second", {3'h0, dac_load, dac_code}, 16'h197E);
    @(negedge clk);

    // R6 R7 reads
    din = 16'hC3A1;
    repeat (3) @(negedge clk);
    rd(3'd6, r); chk("R6 low", {8'h0, r}, 16'h00A1);
    rd(3'd7, r); chk("R7 high", {8'h0, r}, 16'h00C3);
    @(negedge clk);
    chk("R8 idle", {8'h0, bus_rdata}, 16'h0);
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], r); chk("R8 unmapped", {8'h0, r}, 16'h0);
    end

    // R9 two-stage latency
    din = 16'h5E00;
    rd(3'd7, r); chk("R9 edge1 old", {8'h0, r}, 16'h00C3);
    rd(3'd7, r); chk("R9 edge2 old", {8'h0, r}, 16'h00C3);
    rd(3'd7, r); chk("R9 edge3 new", {8'h0, r}, 16'h005E);

    // R2 reset mid-stream clears staging
    wr(3'd4, 8'hEE);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    wr(3'd5, 8'h03);
    chk("R1 staging cleared by reset", {4'h0, dac_code}, 16'h0300);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule